// File: doc/BRIEF.md
# Serial Signature Divider

This block compacts a serial bit stream into a short signature by dividing the stream, read as a polynomial over GF(2), by a fixed divisor of degree five. Each accepted input bit enters a 5-bit shift register that has XOR gates between its stages. Whenever the bit leaving the top stage is 1, the divisor taps are added into the shifted value. The bit that leaves is one coefficient of the quotient. When the stream has ended, the register holds the remainder, and that remainder is the signature.

A test controller clears the register, then presents the response stream one bit per cycle with the highest-order coefficient first, raising the strobe for each bit. It reads the signature once the last bit has been taken. The quotient coefficients appear serially while the stream is being shifted in. For an n-bit register, a faulty stream produces the fault-free signature only about once in 2^n cases.

Top module: `serial_sig_div`

## Requirements
- R1: A high `clr` at a clock edge sets `sig` to 0 and `quo` to 0 at that edge. This holds even when `vld` is high in the same cycle.
- R2: At each edge where `vld` is high and `clr` is low, `quo` takes the value that `sig[4]` had before the edge, which is the next quotient coefficient.
- R3: At such an edge, `sig` becomes the old `sig[3:0]` with `din` appended at bit 0. When the old `sig[4]` was 1, the divisor taps are XORed in as well.
- R4: At an edge where `vld` and `clr` are both low, `sig` and `quo` keep their values, whatever `din` carries.
- R5: The divisor is given by parameter `POLY`. Bit i of `POLY` is the coefficient of x^i, and the x^5 term is implied. The default is 5'b10101, which is x^5+x^4+x^2+1.
- R6: Bits enter highest order first. The stream 1,1,1,1,0,1,0,1 (x^7+x^6+x^5+x^4+x^2+1) gives `sig` = 5'b10100 (x^4+x^2). On the eight edges it gives the `quo` values 0,0,0,0,0,1,0,1, which is quotient x^2+1.
- R7: A stream that is a multiple of the divisor ends with `sig` = 0. For example, 0,0,1,1,0,1,0,1 gives zero.
- R8: Inverting any single bit of a stream changes the final signature.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| clr | input | 1 | Synchronous clear, active high |
| vld | input | 1 | Input bit strobe |
| din | input | 1 | Serial stream bit, highest order first |
| quo | output | 1 | Most recent quotient coefficient |
| sig | output | 5 | Remainder register, the signature |

## Verification
Four properties are checked on every cycle. After a clear, the register and the quotient bit are zero. The quotient bit follows the old top stage on each accepted bit. The lower stages shift up when no reduction takes place, and the bottom stage takes the input bit with the bottom tap folded in. Both outputs hold still while the strobe is low.

Some behaviour concerns whole streams and only the bench's scenarios can show it. These are:
- the exact remainder and quotient sequence of the worked example;
- a zero remainder for multiples of the divisor;
- a changed signature for a stream with one bit in error;
- a clear that arrives in the same cycle as a strobe.

// File: rtl/serial_sig_div.sv
module serial_sig_div #(
  parameter int unsigned W = 5,
  parameter logic [W-1:0] POLY = 5'b10101
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         vld,
  input  logic         din,
  output logic         quo,
  output logic [W-1:0] sig
);

  logic         top;
  logic [W-1:0] nxt;

  assign top = sig[W-1];
  assign nxt = {sig[W-2:0], din} ^ (top ? POLY : '0);

  always_ff @(posedge clk) begin
    if (clr) begin
      sig <= '0;
      quo <= 1'b0;
    end else if (vld) begin
      sig <= nxt;
      quo <= top;
    end
  end

endmodule

module serial_sig_div_chk #(
  parameter int unsigned W = 5,
  parameter logic [W-1:0] POLY = 5'b10101
) (
  input logic         clk,
  input logic         clr,
  input logic         vld,
  input logic         din,
  input logic         quo,
  input logic [W-1:0] sig
);

  p_clear_r1: assert property (@(posedge clk)
    clr |=> (sig == '0) && !quo);

  p_quo_r2: assert property (@(posedge clk) disable iff (clr)
    vld |=> quo == $past(sig[W-1]));

  p_shift_r3: assert property (@(posedge clk) disable iff (clr)
    (vld && !sig[W-1]) |=> sig[W-1:1] == $past(sig[W-2:0]));

  p_lsb_r3: assert property (@(posedge clk) disable iff (clr)
    vld |=> sig[0] == ($past(din) ^ ($past(sig[W-1]) & POLY[0])));

  p_hold_r4: assert property (@(posedge clk) disable iff (clr)
    !vld |=> $stable(sig) && $stable(quo));

endmodule

bind serial_sig_div serial_sig_div_chk #(.W(W), .POLY(POLY)) u_chk (
  .clk(clk), .clr(clr), .vld(vld), .din(din), .quo(quo), .sig(sig)
);

// File: tb/tb_serial_sig_div.sv
`timescale 1ns/1ps
module tb_serial_sig_div;

  logic       clk = 1'b0;
  logic       clr = 1'b1;
  logic       vld = 1'b0;
  logic       din = 1'b0;
  logic       quo;
  logic [4:0] sig;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  serial_sig_div dut (
    .clk(clk), .clr(clr), .vld(vld), .din(din), .quo(quo), .sig(sig)
  );

  // {stream[7:0] MSB first, quotient sequence[7:0], remainder[4:0]}
  localparam logic [20:0] VEC [6] = '{
    {8'b11110101, 8'b00000101, 5'b10100},  // R6 worked example
    {8'b00110101, 8'b00000001, 5'b00000},  // R7 divisor itself
    {8'b10000000, 8'b00000111, 5'b01011},  // R3 x^7 reduction
    {8'b11111111, 8'b00000101, 5'b11110},  // R3 all ones
    {8'b00000000, 8'b00000000, 5'b00000},  // R3 all zeros
    {8'b11110100, 8'b00000101, 5'b10101}   // R8 example with x^0 inverted
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic do_clr();
    clr = 1'b1; vld = 1'b0;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic push(input logic b);
    vld = 1'b1; din = b;
    @(negedge clk);
    vld = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    clr = 1'b0;
    chk("R1 reset sig", {3'b0, sig}, 8'h00);
    chk("R1 reset quo", {7'b0, quo}, 8'h00);

    for (int i = 0; i < 6; i++) begin
      do_clr();
      for (int k = 7; k >= 0; k--) begin
        push(VEC[i][13 + k]);
        chk($sformatf("R2 vec%0d quo bit%0d", i, k), {7'b0, quo}, {7'b0, VEC[i][5 + k]});
      end
      chk($sformatf("R3/R6/R7/R8 vec%0d sig", i), {3'b0, sig}, {3'b0, VEC[i][4:0]});
    end

    // R8: the good and the corrupted streams must differ
    chk("R8 single-bit error differs", {7'b0, VEC[0][4:0] != VEC[5][4:0]}, 8'h01);

    // R4: hold while the strobe is low, with din toggling
    do_clr();
    push(1'b1); push(1'b1); push(1'b1);
    for (int c = 0; c < 4; c++) begin
      din = c[0];
      @(negedge clk);
      chk("R4 hold sig", {3'b0, sig}, 8'b00000111);
      chk("R4 hold quo", {7'b0, quo}, 8'h00);
    end
    push(1'b1); push(1'b0); push(1'b1); push(1'b0); push(1'b1);
    chk("R4/R6 resumed stream sig", {3'b0, sig}, 8'b00010100);
    chk("R6 resumed stream quo", {7'b0, quo}, 8'h01);

    // R1: clear wins over a strobe in the same cycle
    clr = 1'b1; vld = 1'b1; din = 1'b1;
    @(negedge clk);
    clr = 1'b0; vld = 1'b0;
    chk("R1 clear over strobe sig", {3'b0, sig}, 8'h00);
    chk("R1 clear over strobe quo", {7'b0, quo}, 8'h00);

    // R5: default divisor reduces x^5 to the tap pattern
    push(1'b1); push(1'b0); push(1'b0); push(1'b0); push(1'b0); push(1'b0);
    chk("R5 x^5 reduces to taps", {3'b0, sig}, 8'b00010101);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule